// File: doc/BRIEF.md
# Walk and Queue Read ID Tagger

This block collects read requests from three kinds of requester inside a memory-management unit and sends them out on one AXI-style read address channel. The requesters are a set of table-walk slots, one command-queue reader and one DVM-complete issuer. Only one request is granted per cycle. The command-queue reader has priority over the DVM-complete issuer, and the DVM-complete issuer has priority over the walk slots. The walk slots share their turn by round-robin.

Each granted request receives a read ID that encodes where it came from. Bit 0 separates walks from the other sources. For a walk, the upper bits carry the slot number. For the other sources, the upper bits hold one of two reserved patterns. When read data comes back, the block decodes its ID and raises a response strobe towards the single requester that owns it. If the returned ID belongs to no source that has a read in flight, the block raises an error pulse instead. The write address ID is driven as a fixed zero.

Each source may have at most one read in flight. A requester holds its request high until it sees a one-cycle grant. The request is then registered into the address channel and held there until the downstream ready handshake. The number of walk slots is a parameter. The ID width is one more than the slot field, and the slot field is sized so that no slot number can equal the all-ones pattern reserved for DVM complete.

Top module: `walk_rd_id_tagger`

## Requirements
- R1: `aw_id_o` is zero at all times, including during reset.
- R2: A read granted to walk slot k carries `ar_id_o[0]`=1 and `ar_id_o[ID_W-1:1]`=k. Its address is that slot's field of `walk_addr_i` (bits k*ADDR_W upwards).
- R3: A command-queue read carries `ar_id_o` of all zeros and the address `cmdq_addr_i`.
- R4: A DVM-complete read carries all ones in `ar_id_o[ID_W-1:1]`, 0 in bit 0, and a zero address.
- R5: When several eligible sources request in the same cycle, the command queue is granted first, then DVM complete, then the walk slots.
- R6: Among the walk slots, the search for the next grant starts at the slot after the one most recently granted and wraps past the top slot.
- R7: A grant is a one-cycle pulse in the cycle the request is accepted, and `ar_valid_o` rises on the next clock edge. While `ar_valid_o` is high and `ar_ready_i` is low, the ID and address stay unchanged and no new grant is issued. A grant can be issued in the same cycle as the handshake.
- R8: A source that has a read in flight is not granted again until a beat with `r_last_i`=1 and its ID has returned. A beat with `r_last_i`=0 still routes to the source but keeps it in flight.
- R9: A returning beat whose ID belongs to a source with a read in flight raises exactly that source's response strobe, in the same cycle as `r_valid_i`.
- R10: A returning beat whose ID matches no source with a read in flight raises `r_err_o` and no response strobe. Such IDs include an idle source, a walk slot at or above N_WALK, and an ID with bit 0 clear and upper bits that are neither all zeros nor all ones.
- R11: After reset, `ar_valid_o` is low and no source has a read in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| walk_req_i | input | N_WALK | Read request per walk slot |
| walk_addr_i | input | N_WALK*ADDR_W | Read address per walk slot, packed |
| walk_gnt_o | output | N_WALK | Grant pulse per walk slot |
| cmdq_req_i | input | 1 | Command-queue read request |
| cmdq_addr_i | input | ADDR_W | Command-queue read address |
| cmdq_gnt_o | output | 1 | Command-queue grant pulse |
| dvm_req_i | input | 1 | DVM-complete request |
| dvm_gnt_o | output | 1 | DVM-complete grant pulse |
| ar_valid_o | output | 1 | Read address valid |
| ar_ready_i | input | 1 | Read address ready |
| ar_id_o | output | ID_W | Read address ID |
| ar_addr_o | output | ADDR_W | Read address |
| aw_id_o | output | ID_W | Write address ID |
| r_valid_i | input | 1 | Read data valid |
| r_last_i | input | 1 | Final beat of a read |
| r_id_i | input | ID_W | Read data ID |
| walk_rvalid_o | output | N_WALK | Response strobe per walk slot |
| cmdq_rvalid_o | output | 1 | Command-queue response strobe |
| dvm_rvalid_o | output | 1 | DVM-complete response strobe |
| r_err_o | output | 1 | Pulse for a beat with an unmatched ID |

## Verification
The bench drives the command queue, DVM complete and a walk slot in the same cycle. A wrong priority order would grant them in the wrong sequence and put the wrong ID on the channel. It grants slot 1 and then requests slots 0 and 2 together; a fixed-priority arbiter would pick slot 0 where slot 2 is due. It holds `ar_ready_i` low with a second request waiting, which catches an ID that moves during a stall or a grant that is lost. It also returns a non-final beat to a slot that is already busy, where a design that cleared its in-flight mark too early would grant that slot twice. Finally it returns IDs for an idle slot, for an out-of-range slot and for a reserved pattern, each of which must give only the error pulse.

// File: rtl/wtag_pkg.sv
package wtag_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_WALK = 2'd1,
    SRC_CMDQ = 2'd2,
    SRC_DVM  = 2'd3
  } src_e;
endpackage

// File: rtl/wtag_rr_arb.sv
module wtag_rr_arb #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          adv_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      int c;
      c = int'(ptr_q) + i;
      if (c >= N) c = c - N;
      if (!any_o && req_i[c]) begin
        any_o = 1'b1;
        idx_o = IW'(c);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (adv_i) ptr_q <= (int'(idx_o) == N - 1) ? '0 : idx_o + 1'b1;
  end
endmodule

// File: rtl/wtag_id_enc.sv
module wtag_id_enc
  import wtag_pkg::*;
#(
  parameter int SLOT_W = 3,
  localparam int ID_W = SLOT_W + 1
) (
  input  src_e              kind_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [ID_W-1:0]   id_o
);
  always_comb begin
    unique case (kind_i)
      SRC_WALK: id_o = {slot_i, 1'b1};
      SRC_DVM:  id_o = {{SLOT_W{1'b1}}, 1'b0};
      default:  id_o = '0;
    endcase
  end
endmodule

// File: rtl/wtag_id_dec.sv
module wtag_id_dec
  import wtag_pkg::*;
#(
  parameter int SLOT_W = 3,
  localparam int ID_W = SLOT_W + 1
) (
  input  logic [ID_W-1:0]   id_i,
  output src_e              kind_o,
  output logic [SLOT_W-1:0] slot_o
);
  assign slot_o = id_i[ID_W-1:1];

  always_comb begin
    if (id_i[0])             kind_o = SRC_WALK;
    else if (~|id_i[ID_W-1:1]) kind_o = SRC_CMDQ;
    else if (&id_i[ID_W-1:1])  kind_o = SRC_DVM;
    else                     kind_o = SRC_NONE;
  end
endmodule

// File: rtl/walk_rd_id_tagger.sv
module walk_rd_id_tagger
  import wtag_pkg::*;
#(
  parameter int N_WALK = 4,
  parameter int ADDR_W = 16,
  // slot field leaves room for the reserved all-ones pattern
  localparam int SLOT_W = $clog2(N_WALK + 2),
  localparam int ID_W   = SLOT_W + 1,
  localparam int IW     = (N_WALK > 1) ? $clog2(N_WALK) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_WALK-1:0]        walk_req_i,
  input  logic [N_WALK*ADDR_W-1:0] walk_addr_i,
  output logic [N_WALK-1:0]        walk_gnt_o,
  input  logic                     cmdq_req_i,
  input  logic [ADDR_W-1:0]        cmdq_addr_i,
  output logic                     cmdq_gnt_o,
  input  logic                     dvm_req_i,
  output logic                     dvm_gnt_o,
  output logic                     ar_valid_o,
  input  logic                     ar_ready_i,
  output logic [ID_W-1:0]          ar_id_o,
  output logic [ADDR_W-1:0]        ar_addr_o,
  output logic [ID_W-1:0]          aw_id_o,
  input  logic                     r_valid_i,
  input  logic                     r_last_i,
  input  logic [ID_W-1:0]          r_id_i,
  output logic [N_WALK-1:0]        walk_rvalid_o,
  output logic                     cmdq_rvalid_o,
  output logic                     dvm_rvalid_o,
  output logic                     r_err_o
);
  logic [N_WALK-1:0] walk_out_q;
  logic              cmdq_out_q, dvm_out_q;
  logic              ar_valid_q;
  logic [ID_W-1:0]   ar_id_q;
  logic [ADDR_W-1:0] ar_addr_q;

  logic              can_load, load;
  logic              walk_any;
  logic [IW-1:0]     walk_idx;
  src_e              sel_kind;
  logic [ID_W-1:0]   sel_id;
  logic [ADDR_W-1:0] sel_addr;
  src_e              dec_kind;
  logic [SLOT_W-1:0] dec_slot;

  assign aw_id_o  = '0;
  assign can_load = !ar_valid_q || ar_ready_i;

  wtag_rr_arb #(.N(N_WALK)) u_rr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (walk_req_i & ~walk_out_q),
    .adv_i (load && sel_kind == SRC_WALK),
    .any_o (walk_any),
    .idx_o (walk_idx)
  );

  always_comb begin
    if (cmdq_req_i && !cmdq_out_q)     sel_kind = SRC_CMDQ;
    else if (dvm_req_i && !dvm_out_q)  sel_kind = SRC_DVM;
    else if (walk_any)                 sel_kind = SRC_WALK;
    else                               sel_kind = SRC_NONE;
  end

  assign load = can_load && sel_kind != SRC_NONE;

  always_comb begin
    unique case (sel_kind)
      SRC_WALK: sel_addr = walk_addr_i[int'(walk_idx)*ADDR_W +: ADDR_W];
      SRC_CMDQ: sel_addr = cmdq_addr_i;
      default:  sel_addr = '0;
    endcase
  end

  wtag_id_enc #(.SLOT_W(SLOT_W)) u_enc (
    .kind_i(sel_kind),
    .slot_i(SLOT_W'(walk_idx)),
    .id_o  (sel_id)
  );

  assign cmdq_gnt_o = load && sel_kind == SRC_CMDQ;
  assign dvm_gnt_o  = load && sel_kind == SRC_DVM;
  assign walk_gnt_o = (load && sel_kind == SRC_WALK) ? (N_WALK'(1) << walk_idx) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ar_valid_q <= 1'b0;
      ar_id_q    <= '0;
      ar_addr_q  <= '0;
    end else if (can_load) begin
      ar_valid_q <= load;
      if (load) begin
        ar_id_q   <= sel_id;
        ar_addr_q <= sel_addr;
      end
    end
  end

  assign ar_valid_o = ar_valid_q;
  assign ar_id_o    = ar_id_q;
  assign ar_addr_o  = ar_addr_q;

  // response routing
  wtag_id_dec #(.SLOT_W(SLOT_W)) u_dec (
    .id_i  (r_id_i),
    .kind_o(dec_kind),
    .slot_o(dec_slot)
  );

  for (genvar g = 0; g < N_WALK; g++) begin : g_wrv
    assign walk_rvalid_o[g] = r_valid_i && dec_kind == SRC_WALK &&
                              dec_slot == SLOT_W'(g) && walk_out_q[g];
  end

  assign cmdq_rvalid_o = r_valid_i && dec_kind == SRC_CMDQ && cmdq_out_q;
  assign dvm_rvalid_o  = r_valid_i && dec_kind == SRC_DVM && dvm_out_q;
  assign r_err_o       = r_valid_i && !(|walk_rvalid_o) && !cmdq_rvalid_o && !dvm_rvalid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      walk_out_q <= '0;
      cmdq_out_q <= 1'b0;
      dvm_out_q  <= 1'b0;
    end else begin
      walk_out_q <= (walk_out_q | walk_gnt_o) & ~(walk_rvalid_o & {N_WALK{r_last_i}});
      cmdq_out_q <= (cmdq_out_q | cmdq_gnt_o) & ~(cmdq_rvalid_o && r_last_i);
      dvm_out_q  <= (dvm_out_q | dvm_gnt_o) & ~(dvm_rvalid_o && r_last_i);
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_valid_o && !ar_ready_i |=> ar_valid_o && $stable(ar_id_o) && $stable(ar_addr_o));

  // R7
  gnt_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_gnt_o & ~walk_req_i) == '0 && (!cmdq_gnt_o || cmdq_req_i) && (!dvm_gnt_o || dvm_req_i));

  // R5
  cmdq_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dvm_gnt_o || walk_gnt_o != '0) |-> !cmdq_req_i || cmdq_out_q);

  // R9
  resp_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({walk_rvalid_o, cmdq_rvalid_o, dvm_rvalid_o, r_err_o}));

  // R2
  walk_id_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_valid_o && ar_id_o[0] |-> int'(ar_id_o[ID_W-1:1]) < N_WALK);

  // R7
  valid_after_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmdq_gnt_o || dvm_gnt_o || walk_gnt_o != '0) |=> ar_valid_o);
endmodule

// File: tb/sim_walk_rd_id_tagger.sv
module sim_walk_rd_id_tagger;
  localparam int CLK_P  = 10;
  localparam int NW     = 4;
  localparam int AW     = 16;
  localparam int IDW    = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NW-1:0]    walk_req = '0;
  logic [NW*AW-1:0] walk_addr;
  logic [NW-1:0]    walk_gnt;
  logic             cmdq_req = 1'b0, cmdq_gnt, dvm_req = 1'b0, dvm_gnt;
  logic [AW-1:0]    cmdq_addr = 16'h2000;
  logic             ar_valid, ar_ready = 1'b0;
  logic [IDW-1:0]   ar_id, aw_id;
  logic [AW-1:0]    ar_addr;
  logic             r_valid = 1'b0, r_last = 1'b0;
  logic [IDW-1:0]   r_id = '0;
  logic [NW-1:0]    walk_rv;
  logic             cmdq_rv, dvm_rv, r_err;

  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  for (genvar g = 0; g < NW; g++) begin : g_addr
    assign walk_addr[g*AW +: AW] = 16'h1000 + 16'(g);
  end

  walk_rd_id_tagger #(.N_WALK(NW), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .walk_req_i(walk_req), .walk_addr_i(walk_addr), .walk_gnt_o(walk_gnt),
    .cmdq_req_i(cmdq_req), .cmdq_addr_i(cmdq_addr), .cmdq_gnt_o(cmdq_gnt),
    .dvm_req_i(dvm_req), .dvm_gnt_o(dvm_gnt),
    .ar_valid_o(ar_valid), .ar_ready_i(ar_ready), .ar_id_o(ar_id), .ar_addr_o(ar_addr),
    .aw_id_o(aw_id),
    .r_valid_i(r_valid), .r_last_i(r_last), .r_id_i(r_id),
    .walk_rvalid_o(walk_rv), .cmdq_rvalid_o(cmdq_rv), .dvm_rvalid_o(dvm_rv), .r_err_o(r_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // response vector {walk_rv, cmdq_rv, dvm_rv, r_err}
  function automatic logic [31:0] rsp();
    return 32'({walk_rv, cmdq_rv, dvm_rv, r_err});
  endfunction

  task automatic beat(input logic [IDW-1:0] id, input logic last, input logic [6:0] exp, input string tag);
    @(negedge clk);
    r_valid = 1'b1; r_id = id; r_last = last;
    #1 chk(tag, rsp(), 32'(exp));
    @(negedge clk);
    r_valid = 1'b0; r_last = 1'b0;
  endtask

  // kind: 0 walk, 1 cmdq, 2 dvm
  localparam logic [8:0] VEC [0:5] = '{
    {2'd0, 3'd0, 4'b0001},
    {2'd0, 3'd1, 4'b0011},
    {2'd1, 3'd0, 4'b0000},
    {2'd0, 3'd3, 4'b0111},
    {2'd2, 3'd0, 4'b1110},
    {2'd0, 3'd2, 4'b0101}
  };

  initial begin
    #(CLK_P * 100000);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    chk("R1 aw_id in reset", 32'(aw_id), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ar_valid after reset", 32'(ar_valid), 0);
    chk("R1 aw_id after reset", 32'(aw_id), 0);
    chk("R11 no grant when idle", 32'({walk_gnt, cmdq_gnt, dvm_gnt}), 0);
    beat(4'b0000, 1'b1, 7'b0000001, "R11 nothing in flight after reset");

    // table of single-source reads
    for (int v = 0; v < 6; v++) begin
      logic [1:0] kind; logic [2:0] slot; logic [3:0] eid; logic [AW-1:0] eaddr;
      logic [6:0] ersp; string tg;
      kind = VEC[v][8:7]; slot = VEC[v][6:4]; eid = VEC[v][3:0];
      case (kind)
        2'd0: begin eaddr = 16'h1000 + 16'(slot); ersp = 7'(1 << (3 + slot)); tg = "R2"; end
        2'd1: begin eaddr = 16'h2000; ersp = 7'b0000100; tg = "R3"; end
        default: begin eaddr = 16'h0; ersp = 7'b0000010; tg = "R4"; end
      endcase
      @(negedge clk);
      ar_ready = 1'b1;
      if (kind == 0) walk_req[slot] = 1'b1;
      else if (kind == 1) cmdq_req = 1'b1;
      else dvm_req = 1'b1;
      #1 chk({tg, " grant pulse R7"}, 32'({walk_gnt, cmdq_gnt, dvm_gnt}), 32'(ersp[6:1]));
      @(negedge clk);
      walk_req = '0; cmdq_req = 1'b0; dvm_req = 1'b0;
      chk({tg, " ar_valid R7"}, 32'(ar_valid), 1);
      chk({tg, " ar_id"}, 32'(ar_id), 32'(eid));
      chk({tg, " ar_addr"}, 32'(ar_addr), 32'(eaddr));
      @(negedge clk);
      ar_ready = 1'b0;
      chk({tg, " valid drops R7"}, 32'(ar_valid), 0);
      beat(eid, 1'b1, ersp, {tg, " R9 routing"});
    end

    // R5 priority: all three at once
    @(negedge clk);
    ar_ready = 1'b1; cmdq_req = 1'b1; dvm_req = 1'b1; walk_req = 4'b1000;
    #1 chk("R5 cmdq first", 32'({walk_gnt, cmdq_gnt, dvm_gnt}), 32'(6'b000010));
    @(negedge clk);
    cmdq_req = 1'b0;
    #1 chk("R5 dvm second", 32'({walk_gnt, cmdq_gnt, dvm_gnt}), 32'(6'b000001));
    chk("R3 cmdq id", 32'(ar_id), 0);
    @(negedge clk);
    dvm_req = 1'b0;
    #1 chk("R5 walk last", 32'({walk_gnt, cmdq_gnt, dvm_gnt}), 32'(6'b100000));
    chk("R4 dvm id", 32'(ar_id), 32'(4'b1110));
    chk("R4 dvm addr", 32'(ar_addr), 0);
    @(negedge clk);
    walk_req = '0;
    chk("R2 walk3 id", 32'(ar_id), 32'(4'b0111));
    @(negedge clk);
    ar_ready = 1'b0;
    beat(4'b0000, 1'b1, 7'b0000100, "R9 cmdq back");
    beat(4'b1110, 1'b1, 7'b0000010, "R9 dvm back");
    beat(4'b0111, 1'b1, 7'b1000000, "R9 walk3 back");

    // R7 stall
    @(negedge clk);
    walk_req = 4'b0100;
    #1 chk("R7 walk2 grant", 32'(walk_gnt), 32'(4'b0100));
    @(negedge clk);
    walk_req = 4'b0001;
    #1 chk("R7 no grant while stalled", 32'(walk_gnt), 0);
    chk("R7 id held", 32'(ar_id), 32'(4'b0101));
    repeat (2) @(negedge clk);
    #1 chk("R7 still held", 32'({ar_valid, ar_id}), 32'(5'b10101));
    chk("R7 still no grant", 32'(walk_gnt), 0);
    ar_ready = 1'b1;
    #1 chk("R7 grant on handshake", 32'(walk_gnt), 32'(4'b0001));
    @(negedge clk);
    walk_req = '0;
    chk("R7 next id", 32'(ar_id), 32'(4'b0001));
    @(negedge clk);
    ar_ready = 1'b0;
    beat(4'b0101, 1'b1, 7'b0100000, "R9 walk2 back");
    beat(4'b0001, 1'b1, 7'b0001000, "R9 walk0 back");

    // R6 round robin: grant 1, then 0 and 2 together -> 2
    @(negedge clk);
    ar_ready = 1'b1; walk_req = 4'b0010;
    #1 chk("R6 walk1 grant", 32'(walk_gnt), 32'(4'b0010));
    @(negedge clk);
    walk_req = 4'b0101;
    #1 chk("R6 slot after last wins", 32'(walk_gnt), 32'(4'b0100));
    @(negedge clk);
    walk_req = 4'b0001;
    #1 chk("R6 wrap to slot0", 32'(walk_gnt), 32'(4'b0001));
    @(negedge clk);
    walk_req = '0;
    @(negedge clk);
    ar_ready = 1'b0;
    beat(4'b0011, 1'b1, 7'b0010000, "R9 walk1 back");
    beat(4'b0101, 1'b1, 7'b0100000, "R9 walk2 back rr");
    beat(4'b0001, 1'b1, 7'b0001000, "R9 walk0 back rr");

    // R8 one read in flight per source
    @(negedge clk);
    ar_ready = 1'b1; walk_req = 4'b1000;
    @(negedge clk);
    walk_req = '0;
    @(negedge clk);
    walk_req = 4'b1000;
    #1 chk("R8 busy slot not granted", 32'(walk_gnt), 0);
    r_valid = 1'b1; r_id = 4'b0111; r_last = 1'b0;
    #1 chk("R8 partial beat routed", rsp(), 32'(7'b1000000));
    @(negedge clk);
    r_valid = 1'b0;
    #1 chk("R8 still busy after partial", 32'(walk_gnt), 0);
    r_valid = 1'b1; r_last = 1'b1;
    @(negedge clk);
    r_valid = 1'b0; r_last = 1'b0;
    #1 chk("R8 granted after last beat", 32'(walk_gnt), 32'(4'b1000));
    @(negedge clk);
    walk_req = '0;
    @(negedge clk);
    ar_ready = 1'b0;
    beat(4'b0111, 1'b1, 7'b1000000, "R9 walk3 final");

    // R10 unmatched ids
    beat(4'b0011, 1'b1, 7'b0000001, "R10 idle slot id");
    beat(4'b1011, 1'b1, 7'b0000001, "R10 out of range slot");
    beat(4'b0100, 1'b1, 7'b0000001, "R10 reserved pattern");
    beat(4'b1110, 1'b1, 7'b0000001, "R10 idle dvm id");
    chk("R1 aw_id at end", 32'(aw_id), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule